// File: doc/BRIEF.md
# Register-Started NVM Word Reader

This block reads 16-bit words from a non-volatile store through one 32-bit control register. A read starts when the start bit and a word address are written into that register. The register then clears its done flag and sends one read to the storage port. When the storage answers, the register sets done and holds the returned word in its upper half.

On top of that register sits a sequencer. It takes a request made of a starting word offset and a word count. It first checks the request against the storage size. It then starts one read per word at consecutive addresses, and after each start it polls the done flag at a fixed interval. Each word is handed out with its index. The request ends with one status pulse: success, out of range, or timeout. A timeout means that done did not appear within a bounded number of polls, and it stops the request at that word.

Top module: `nvm_word_reader`

## Requirements
- R1: After reset, `ctl_reg` reads 0, `busy` is low, and `mem_rd_en`, `word_valid` and `rsp_valid` are low.
- R2: Register layout: bit 0 is start and always reads back 0; bit 1 is done; bits 15:2 hold the word address; bits 31:16 hold the returned data.
- R3: Writing a start clears done and the data field and loads the address field. In the same cycle that the register shows this, the block raises `mem_rd_en` for exactly one cycle, with `mem_addr` equal to the address field.
- R4: A storage response (`mem_rd_valid`) to an outstanding read sets done and loads `mem_rd_data` into bits 31:16. Done is never set without a response.
- R5: A request with offset O and count N starts exactly N reads, at addresses O, O+1, … O+N−1 in that order. Word i is presented on `word_data` with `word_index` = i.
- R6: Done is polled in the first cycle after each start and then every CLKS_PER_US×POLL_US cycles. The request ends with one `rsp_valid` pulse with status 0 (success), and `busy` is low from that cycle on.
- R7: If POLL_LIMIT polls in a row find done clear, the request ends with status 2 (timeout). No further reads start, and the words already delivered stay delivered.
- R8: A request with offset ≥ NVM_WORDS, count 0, or offset+count > NVM_WORDS ends in the next cycle with status 1 (range) and starts no read. A request that ends exactly at NVM_WORDS is accepted.
- R9: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_offset | input | 14 | First word address |
| req_count | input | CNT_W | Number of words |
| busy | output | 1 | Request in progress |
| word_valid | output | 1 | One-cycle pulse per word read |
| word_index | output | CNT_W | Position of the word in the request |
| word_data | output | 16 | Word read |
| rsp_valid | output | 1 | One-cycle pulse at end of request |
| rsp_status | output | 2 | 0 success, 1 range, 2 timeout |
| ctl_reg | output | 32 | Current control register value |
| mem_rd_en | output | 1 | Storage read pulse |
| mem_addr | output | 14 | Storage word address |
| mem_rd_valid | input | 1 | Storage response strobe |
| mem_rd_data | input | 16 | Storage response word |

## Verification
A done flag that is left stale across a new start would deliver the previous word at the very first poll, one cycle after the start. The bench catches this because it compares every word with a storage model keyed by address. A wrong address or index counter shows up on the first `mem_rd_en` or `word_valid` that carries the wrong value. An attempt counter or poll interval that is off moves the timeout status pulse out of a tight cycle window, so the bench sees it when the request ends. A faulty range check shows up one cycle after the request, either as a read pulse where there should be none or as a wrong status.

// File: rtl/nvm_rd_pkg.sv
// Shared layout of the control register and the status codes of the reader.
package nvm_rd_pkg;
    localparam int REG_W    = 32;
    localparam int START_B  = 0;
    localparam int DONE_B   = 1;
    localparam int ADDR_LSB = 2;
    localparam int ADDR_W   = 14;
    localparam int DATA_LSB = 16;
    localparam int DATA_W   = 16;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_RANGE   = 2'd1,
        ST_TIMEOUT = 2'd2
    } rd_status_e;
endpackage

// File: rtl/nvm_ctl_reg.sv
// Control register: holds start/done/address/data. A write with start set
// launches one storage read. Assumes at most one read is outstanding.
module nvm_ctl_reg
    import nvm_rd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                mem_rd_valid,
    input  logic [DATA_W-1:0]   mem_rd_data,
    output logic [REG_W-1:0]    reg_q,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q;
    logic              pend_q;

    // Register update: start clears done/data and issues a read; a response fills them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            data_q    <= '0;
            done_q    <= 1'b0;
            pend_q    <= 1'b0;
            mem_rd_en <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            if (wr_en && wr_data[START_B]) begin
                addr_q    <= wr_data[ADDR_LSB +: ADDR_W];
                data_q    <= '0;
                done_q    <= 1'b0;
                pend_q    <= 1'b1;
                mem_rd_en <= 1'b1;
            end else if (mem_rd_valid && pend_q) begin
                data_q <= mem_rd_data;
                done_q <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end

    // Read-back value; the start bit is self-clearing.
    always_comb begin
        reg_q = {data_q, addr_q, done_q, 1'b0};
    end

    assign mem_addr = addr_q;
endmodule

// File: rtl/nvm_poll_timer.sv
// Poll pacing: first poll right after arming, then one every GAP cycles;
// flags the poll that uses up the attempt budget. Assumes GAP >= 1, LIMIT >= 1.
module nvm_poll_timer #(
    parameter int GAP   = 1000,
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic poll_now,
    output logic last_poll
);
    localparam int GAP_W = $clog2(GAP + 1);
    localparam int TRY_W = $clog2(LIMIT + 1);

    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] tries_q;

    assign poll_now  = run && (gap_q == '0);
    assign last_poll = poll_now && (tries_q == TRY_W'(LIMIT - 1));

    // Interval counter and attempt counter.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            gap_q   <= '0;
            tries_q <= '0;
        end else if (run) begin
            if (gap_q == '0) begin
                gap_q   <= GAP_W'(GAP - 1);
                tries_q <= tries_q + 1'b1;
            end else begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvm_range_chk.sv
// Request bounds check: offset inside the store, nonzero count, no overrun.
module nvm_range_chk #(
    parameter int WORDS  = 1024,
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 11
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [CNT_W-1:0]  count,
    output logic              ok
);
    logic [31:0] off32;
    logic [31:0] cnt32;

    // Compare in a wide domain so no term can wrap.
    always_comb begin
        off32 = 32'(offset);
        cnt32 = 32'(count);
        ok    = (off32 < 32'(WORDS)) && (cnt32 != 32'd0) &&
                (cnt32 <= (32'(WORDS) - off32));
    end
endmodule

// File: rtl/nvm_word_reader.sv
// Multi-word reader: range-checks a request, then starts one register read
// per word and polls done with a bounded attempt count.
// Assumes NVM_WORDS <= 2**14.
module nvm_word_reader
    import nvm_rd_pkg::*;
#(
    parameter int NVM_WORDS   = 1024,
    parameter int CLKS_PER_US = 200,
    parameter int POLL_US     = 5,
    parameter int POLL_LIMIT  = 100000,
    parameter int CNT_W       = $clog2(NVM_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_offset,
    input  logic [CNT_W-1:0]    req_count,
    output logic                busy,
    output logic                word_valid,
    output logic [CNT_W-1:0]    word_index,
    output logic [DATA_W-1:0]   word_data,
    output logic                rsp_valid,
    output logic [1:0]          rsp_status,
    output logic [REG_W-1:0]    ctl_reg,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_rd_valid,
    input  logic [DATA_W-1:0]   mem_rd_data
);
    localparam int GAP = CLKS_PER_US * POLL_US;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_e;

    seq_e              state_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx_q;
    logic              range_ok;
    logic              poll_now;
    logic              last_poll;
    logic              wr_en;
    logic [REG_W-1:0]  wr_data;
    logic [ADDR_W-1:0] cur_addr;
    rd_status_e        status_q;

    nvm_range_chk #(.WORDS(NVM_WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_range (
        .offset (req_offset),
        .count  (req_count),
        .ok     (range_ok)
    );

    nvm_ctl_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .reg_q        (ctl_reg),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr)
    );

    nvm_poll_timer #(.GAP(GAP), .LIMIT(POLL_LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (state_q == S_ISSUE),
        .run       (state_q == S_WAIT),
        .poll_now  (poll_now),
        .last_poll (last_poll)
    );

    // Start word: address of the current word in its field, start bit set.
    always_comb begin
        cur_addr = base_q + ADDR_W'(idx_q);
        wr_en    = (state_q == S_ISSUE);
        wr_data  = {{DATA_W{1'b0}}, cur_addr, 1'b0, 1'b1};
    end

    // Sequencer: accept, issue one start per word, poll, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            base_q     <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
            word_valid <= 1'b0;
            word_index <= '0;
            word_data  <= '0;
            rsp_valid  <= 1'b0;
            status_q   <= ST_OK;
        end else begin
            word_valid <= 1'b0;
            rsp_valid  <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        if (range_ok) begin
                            base_q  <= req_offset;
                            cnt_q   <= req_count;
                            idx_q   <= '0;
                            state_q <= S_ISSUE;
                        end else begin
                            rsp_valid <= 1'b1;
                            status_q  <= ST_RANGE;
                        end
                    end
                end
                S_ISSUE: state_q <= S_WAIT;
                S_WAIT: begin
                    if (poll_now && ctl_reg[DONE_B]) begin
                        word_valid <= 1'b1;
                        word_index <= idx_q;
                        word_data  <= ctl_reg[DATA_LSB +: DATA_W];
                        if (CNT_W'(idx_q + 1'b1) == cnt_q) begin
                            rsp_valid <= 1'b1;
                            status_q  <= ST_OK;
                            state_q   <= S_IDLE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= S_ISSUE;
                        end
                    end else if (last_poll) begin
                        rsp_valid <= 1'b1;
                        status_q  <= ST_TIMEOUT;
                        state_q   <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign rsp_status = status_q;
endmodule

// File: rtl/nvm_word_reader_chk.sv
// Port-level checker for the word reader, attached by bind.
module nvm_word_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        word_valid,
    input logic        rsp_valid,
    input logic [1:0]  rsp_status,
    input logic [31:0] ctl_reg,
    input logic        mem_rd_en,
    input logic        mem_rd_valid
);
    assert_start_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_reg[0]);

    assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !ctl_reg[1] && ctl_reg[31:16] == 16'h0);

    assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_done_from_storage_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_reg[1]) |-> $past(mem_rd_valid));

    assert_word_in_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(busy));

    assert_rsp_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    assert_range_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1) |-> !mem_rd_en);
endmodule

bind nvm_word_reader nvm_word_reader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .word_valid   (word_valid),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .ctl_reg      (ctl_reg),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_valid (mem_rd_valid)
);

// File: tb/nvm_word_reader_bench.sv
// Directed bench: one task per scenario, behavioural storage with set latency.
module nvm_word_reader_bench;
    localparam int WORDS = 64;
    localparam int CPU   = 2;
    localparam int PUS   = 5;
    localparam int LIM   = 6;
    localparam int GAP   = CPU * PUS;
    localparam int CW    = $clog2(WORDS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [13:0]   req_offset = '0;
    logic [CW-1:0] req_count = '0;
    logic          busy, word_valid, rsp_valid, mem_rd_en;
    logic [CW-1:0] word_index;
    logic [15:0]   word_data;
    logic [1:0]    rsp_status;
    logic [31:0]   ctl_reg;
    logic [13:0]   mem_addr;
    logic          mem_rd_valid = 1'b0;
    logic [15:0]   mem_rd_data = '0;

    nvm_word_reader #(.NVM_WORDS(WORDS), .CLKS_PER_US(CPU), .POLL_US(PUS),
                      .POLL_LIMIT(LIM)) u_nvm_word_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_count(req_count), .busy(busy), .word_valid(word_valid),
        .word_index(word_index), .word_data(word_data), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .ctl_reg(ctl_reg), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int lat = 3, stall_after = -1, served = 0;
    int issue_n = 0, word_n = 0, rsp_n = 0, rsp_cyc = 0, last_status = 0;
    int issue_addr [64];
    int got_idx [64];
    int got_data [64];
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int model(input int a);
        return (a * 16'h0131 ^ 16'hA5C3) & 16'hFFFF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Behavioural storage: answers each read after lat cycles unless stalled.
    initial forever begin
        @(negedge clk);
        mem_rd_valid = 1'b0;
        if (mem_rd_en && !(stall_after >= 0 && served >= stall_after)) begin
            automatic int a = int'(mem_addr);
            repeat (lat) @(negedge clk);
            mem_rd_valid = 1'b1;
            mem_rd_data  = 16'(model(a));
            served++;
        end
    end

    // Monitor: logs reads, words and responses; checks R3 at each read pulse.
    initial forever begin
        @(negedge clk);
        if (rst_n && mem_rd_en) begin
            check(ctl_reg[1] == 1'b0, "R3 done cleared on start", int'(ctl_reg[1]), 0);
            check(ctl_reg[15:2] == mem_addr, "R3 address field", int'(ctl_reg[15:2]), int'(mem_addr));
            if (issue_n < 64) issue_addr[issue_n] = int'(mem_addr);
            issue_n++;
        end
        if (rst_n && word_valid) begin
            if (word_n < 64) begin
                got_idx[word_n]  = int'(word_index);
                got_data[word_n] = int'(word_data);
            end
            word_n++;
        end
        if (rst_n && rsp_valid) begin
            rsp_n++;
            rsp_cyc = cyc;
            last_status = int'(rsp_status);
        end
    end

    task automatic send(input int off, input int cnt, output int t0);
        issue_n = 0; word_n = 0; rsp_n = 0; served = 0;
        @(negedge clk);
        t0 = cyc;
        req_valid  = 1'b1;
        req_offset = 14'(off);
        req_count  = CW'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        int w = 0;
        while (rsp_n == 0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic check_words(input string req, input int off, input int n);
        check(word_n == n, {req, " word count"}, word_n, n);
        check(issue_n == n, {req, " read count"}, issue_n, n);
        for (int i = 0; i < n && i < 64; i++) begin
            check(issue_addr[i] == off + i, {req, " read address"}, issue_addr[i], off + i);
            check(got_idx[i] == i, {req, " word index"}, got_idx[i], i);
            check(got_data[i] == model(off + i), {req, " word data"}, got_data[i], model(off + i));
        end
    endtask

    task automatic t_reset();
        check(ctl_reg == 32'h0, "R1 register at reset", int'(ctl_reg), 0);
        check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        check(!mem_rd_en && !word_valid && !rsp_valid, "R1 pulses at reset",
              int'({mem_rd_en, word_valid, rsp_valid}), 0);
    endtask

    task automatic t_single();
        int t0;
        lat = 3;
        send(5, 1, t0);
        wait_rsp();
        check(last_status == 0, "R6 single status", last_status, 0);
        check_words("R5 single", 5, 1);
        check(ctl_reg[1] == 1'b1, "R4 done set", int'(ctl_reg[1]), 1);
        check(ctl_reg[0] == 1'b0, "R2 start reads zero", int'(ctl_reg[0]), 0);
        check(int'(ctl_reg[31:16]) == model(5), "R4 data field", int'(ctl_reg[31:16]), model(5));
        check(int'(ctl_reg[15:2]) == 5, "R2 address field", int'(ctl_reg[15:2]), 5);
        check(busy == 1'b0, "R6 idle after response", int'(busy), 0);
    endtask

    task automatic t_multi();
        int t0;
        lat = 2;
        send(10, 4, t0);
        wait_rsp();
        check(last_status == 0, "R5 multi status", last_status, 0);
        check_words("R5 multi", 10, 4);
    endtask

    task automatic t_slow_end();
        int t0;
        lat = 25;
        send(WORDS - 4, 4, t0);
        wait_rsp();
        check(last_status == 0, "R6 slow storage status", last_status, 0);
        check_words("R8 range end accepted", WORDS - 4, 4);
    endtask

    task automatic t_timeout();
        int t0, d;
        stall_after = 0;
        send(3, 3, t0);
        wait_rsp();
        d = rsp_cyc - t0;
        check(last_status == 2, "R7 timeout status", last_status, 2);
        check(word_n == 0, "R7 no words", word_n, 0);
        check(issue_n == 1, "R7 single read", issue_n, 1);
        check(d >= (LIM - 1) * GAP && d <= (LIM - 1) * GAP + 6, "R7 poll bound timing",
              d, (LIM - 1) * GAP + 3);
        stall_after = -1;
    endtask

    task automatic t_partial();
        int t0;
        lat = 3;
        stall_after = 2;
        send(20, 4, t0);
        wait_rsp();
        check(last_status == 2, "R7 partial timeout status", last_status, 2);
        check(word_n == 2, "R7 words before timeout", word_n, 2);
        check(issue_n == 3, "R7 stops at failed word", issue_n, 3);
        check(got_data[1] == model(21), "R7 kept word", got_data[1], model(21));
        stall_after = -1;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_range();
        int t0;
        int offs [3] = '{WORDS, 4, WORDS - 4};
        int cnts [3] = '{1, 0, 5};
        for (int k = 0; k < 3; k++) begin
            send(offs[k], cnts[k], t0);
            wait_rsp();
            check(last_status == 1, "R8 range status", last_status, 1);
            check(rsp_cyc - t0 <= 2, "R8 immediate response", rsp_cyc - t0, 1);
            check(issue_n == 0, "R8 no read issued", issue_n, 0);
        end
    endtask

    task automatic t_busy_ignore();
        int t0;
        lat = 3;
        send(30, 2, t0);
        @(negedge clk);
        req_valid = 1'b1; req_offset = 14'd0; req_count = CW'(1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp();
        repeat (40) @(negedge clk);
        check(rsp_n == 1, "R9 one response", rsp_n, 1);
        check_words("R9 request while busy ignored", 30, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_slow_end();
        t_timeout();
        t_partial();
        t_range();
        t_busy_ignore();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule